// File: doc/BRIEF.md
# Three-Port Egress Mask Filter

This block sits beside the address-lookup stage of a small switch with two network ports and one processor port. For each received frame it takes the ingress port number, the lookup outcome (a hit flag, a destination mask and a static-override bit) and a directed-send flag for processor traffic. From these it forms a registered egress port mask and a learn-enable strobe. Each network port holds a spanning-tree state that decides its transmit, receive and learning permissions. The processor port is always allowed to send and to receive.

A repeater mode can replace the normal decision. In that mode every frame goes to all ports other than the one it came from, and no address is learned. The mode only engages while all ports are qualified as 100 Mb/s half duplex and both network ports run without auto-negotiation. The decision latency is one clock in every mode, so the repeat delay between network ports never varies.

The design has three state machines. Each network port has a port-state machine with the states DISABLED, BLOCKING, LISTENING, LEARNING and FORWARDING. A write of a valid code takes the transition to the coded state, and any other write keeps the current state. The repeater-mode machine moves from RPT_OFF to RPT_ON when enable and qualification all hold, and from RPT_ON back to RPT_OFF as soon as any of them drops. The decision machine goes from DEC_IDLE to DEC_OUT on a request, stays in DEC_OUT on a back-to-back request, and returns to DEC_IDLE otherwise.

Top module: `fwd_mask_filter`

## Requirements
- R1: After reset, `res_valid`, `egress_mask` and `learn_en` are 0. Both network ports are in the DISABLED state and repeater mode is off.
- R2: `res_valid` is high for exactly the cycle after each cycle in which `req_valid` is high. The mask and learn result of that request appear in the same cycle.
- R3: The egress mask never has the bit of the ingress port set. Port index i maps to mask bit i: 0 and 1 are the network ports and 2 is the processor.
- R4: `cfg_state` codes give (transmit, receive, learn-disable) as follows: 0 DISABLED (0,0,1), 1 BLOCKING (0,0,1), 2 LISTENING (0,0,1), 3 LEARNING (0,0,0), 4 FORWARDING (1,1,0). A write with code 5, 6 or 7 leaves the port state unchanged.
- R5: A frame from a network port whose receive permission is 0 yields an empty mask. The exception is a lookup hit with the override bit set, which yields the processor bit only.
- R6: For network ingress, `learn_en` equals the inverse of that port's learn-disable permission, whatever its receive permission. For processor ingress in normal mode, `learn_en` is 1.
- R7: A lookup miss floods the frame to every non-ingress port that may transmit. The processor port always counts as able to transmit.
- R8: A lookup hit sends the frame to the lookup mask, restricted to ports that may transmit and excluding the ingress port.
- R9: A processor frame with `cpu_directed` set goes to the network-port bits of the lookup mask, regardless of transmit permission.
- R10: While repeater mode is active, the mask holds every port except the ingress port and `learn_en` is 0. Lookup inputs have no effect.
- R11: Repeater mode is active from the cycle after `rpt_en`, all `port_hd100` bits and all `an_off` bits are high. It ends the cycle after any of them drops. Otherwise `rpt_en` is ignored.
- R12: Source index 3 is unused. A request carrying it yields an empty mask and `learn_en` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Port-state write strobe |
| cfg_port | input | 2 | Network port written (0 or 1) |
| cfg_state | input | 3 | Port-state code |
| rpt_en | input | 1 | Repeater mode request |
| port_hd100 | input | 3 | Per-port 100 Mb/s half-duplex qualification |
| an_off | input | 2 | Auto-negotiation disabled, per network port |
| req_valid | input | 1 | Decision request |
| req_src | input | 2 | Ingress port index |
| lkp_hit | input | 1 | Destination lookup hit |
| lkp_mask | input | 3 | Destination port mask from lookup |
| lkp_override | input | 1 | Static override bit of the hit entry |
| cpu_directed | input | 1 | Processor frame directed to the lookup mask ports |
| res_valid | output | 1 | Result valid pulse |
| egress_mask | output | 3 | Registered egress port mask |
| learn_en | output | 1 | Source address may be learned |

## Verification
The bench builds the block with its default of three ports, which gives a two-bit source index. That width makes the unused index 3 reachable, and it lets every port-state code, including the three invalid ones, be written to either network port. The small port count means every pairing of ingress port and port state can be reached in a few short requests. It also makes the repeater qualification reachable both with one qualification bit missing and with all of them present.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        STP_DISABLED   = 3'd0,
        STP_BLOCKING   = 3'd1,
        STP_LISTENING  = 3'd2,
        STP_LEARNING   = 3'd3,
        STP_FORWARDING = 3'd4
    } stp_state_e;

    typedef enum logic {
        RPT_OFF = 1'b0,
        RPT_ON  = 1'b1
    } rpt_state_e;

    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_OUT  = 1'b1
    } dec_state_e;

    typedef enum logic [2:0] {
        PATH_DROP,
        PATH_REPEAT,
        PATH_DIRECTED,
        PATH_OVERRIDE,
        PATH_LOOKUP,
        PATH_FLOOD
    } path_e;

    typedef struct packed {
        logic tx;
        logic rx;
        logic learn_dis;
    } port_perm_t;

endpackage

// File: rtl/stp_port_ctl.sv
module stp_port_ctl
    import fwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] wr_code,
    output logic              tx_en,
    output logic              rx_en,
    output logic              learn_dis
);

    stp_state_e state_q;
    stp_state_e state_d;
    port_perm_t perm;

    // Next state: a valid code selects its state, any other code holds.
    always_comb begin
        state_d = state_q;
        if (wr) begin
            unique case (wr_code)
                3'd0:    state_d = STP_DISABLED;
                3'd1:    state_d = STP_BLOCKING;
                3'd2:    state_d = STP_LISTENING;
                3'd3:    state_d = STP_LEARNING;
                3'd4:    state_d = STP_FORWARDING;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STP_DISABLED;
        else        state_q <= state_d;
    end

    // Outputs: permissions per state.
    always_comb begin
        unique case (state_q)
            STP_DISABLED:   perm = '{tx: 1'b0, rx: 1'b0, learn_dis: 1'b1};
            STP_BLOCKING:   perm = '{tx: 1'b0, rx: 1'b0, learn_dis: 1'b1};
            STP_LISTENING:  perm = '{tx: 1'b0, rx: 1'b0, learn_dis: 1'b1};
            STP_LEARNING:   perm = '{tx: 1'b0, rx: 1'b0, learn_dis: 1'b0};
            STP_FORWARDING: perm = '{tx: 1'b1, rx: 1'b1, learn_dis: 1'b0};
            default:        perm = '{tx: 1'b0, rx: 1'b0, learn_dis: 1'b1};
        endcase
    end

    assign tx_en     = perm.tx;
    assign rx_en     = perm.rx;
    assign learn_dis = perm.learn_dis;

    // R4: transmit permission only ever comes with receive and learning
    a_r4_tx_implies_rx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (rx_en && !learn_dis));

    // R4: an invalid code write leaves the permissions as they were
    a_r4_bad_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_code > 3'd4) |=> ($stable(tx_en) && $stable(rx_en) && $stable(learn_dis)));

endmodule

// File: rtl/rpt_mode_fsm.sv
module rpt_mode_fsm
    import fwd_pkg::*;
#(
    parameter int NPORTS = 3,
    localparam int NET   = NPORTS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rpt_en,
    input  logic [NPORTS-1:0] port_hd100,
    input  logic [NET-1:0]    an_off,
    output logic              rpt_active
);

    rpt_state_e state_q;
    rpt_state_e state_d;
    logic       qualified;

    assign qualified = rpt_en && (&port_hd100) && (&an_off);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RPT_OFF: if (qualified)  state_d = RPT_ON;
            RPT_ON:  if (!qualified) state_d = RPT_OFF;
            default: state_d = RPT_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RPT_OFF;
        else        state_q <= state_d;
    end

    assign rpt_active = (state_q == RPT_ON);

    // R11: active mode needs enable and full qualification one cycle earlier
    a_r11_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_active |-> $past(rpt_en && (&port_hd100) && (&an_off)));

    // R11: losing any condition ends the mode on the next cycle
    a_r11_drop_exits: assert property (@(posedge clk) disable iff (!rst_n)
        !(rpt_en && (&port_hd100) && (&an_off)) |=> !rpt_active);

endmodule

// File: rtl/fwd_decide.sv
module fwd_decide
    import fwd_pkg::*;
#(
    parameter int NPORTS = 3,
    localparam int NET   = NPORTS - 1,
    localparam int CPU   = NPORTS - 1,
    localparam int PW    = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PW-1:0]     req_src,
    input  logic              lkp_hit,
    input  logic [NPORTS-1:0] lkp_mask,
    input  logic              lkp_override,
    input  logic              cpu_directed,
    input  logic [NET-1:0]    tx_en,
    input  logic [NET-1:0]    rx_en,
    input  logic [NET-1:0]    learn_dis,
    input  logic              rpt_active,
    output logic              res_valid,
    output logic [NPORTS-1:0] egress_mask,
    output logic              learn_en
);

    logic [NPORTS-1:0] tx_full;
    logic [NPORTS-1:0] net_bits;
    logic [NPORTS-1:0] cpu_bit;
    logic [NPORTS-1:0] src_oh;
    logic              src_ok;
    logic              from_cpu;
    logic              sel_rx;
    logic              sel_ld;
    path_e             path;
    logic [NPORTS-1:0] mask_d;
    logic              learn_d;
    dec_state_e        state_q;
    dec_state_e        state_d;
    logic [NPORTS-1:0] mask_q;
    logic              learn_q;

    // The processor port is always allowed to transmit.
    assign tx_full  = {1'b1, tx_en};
    assign net_bits = {1'b0, {NET{1'b1}}};
    assign cpu_bit  = {1'b1, {NET{1'b0}}};
    assign from_cpu = (req_src == PW'(CPU));

    // Decode the ingress index and pick that port's permissions.
    always_comb begin
        src_ok = 1'b0;
        src_oh = '0;
        sel_rx = 1'b1;
        sel_ld = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (req_src == PW'(i)) begin
                src_ok    = 1'b1;
                src_oh[i] = 1'b1;
            end
        end
        for (int i = 0; i < NET; i++) begin
            if (req_src == PW'(i)) begin
                sel_rx = rx_en[i];
                sel_ld = learn_dis[i];
            end
        end
    end

    // Classify the request into one forwarding path.
    always_comb begin
        if (!src_ok)                    path = PATH_DROP;
        else if (rpt_active)            path = PATH_REPEAT;
        else if (from_cpu && cpu_directed) path = PATH_DIRECTED;
        else if (!from_cpu && !sel_rx)  path = (lkp_hit && lkp_override) ? PATH_OVERRIDE : PATH_DROP;
        else if (lkp_hit)               path = PATH_LOOKUP;
        else                            path = PATH_FLOOD;
    end

    always_comb begin
        mask_d = '0;
        unique case (path)
            PATH_DROP:     mask_d = '0;
            PATH_REPEAT:   mask_d = ~src_oh;
            PATH_DIRECTED: mask_d = lkp_mask & net_bits;
            PATH_OVERRIDE: mask_d = cpu_bit;
            PATH_LOOKUP:   mask_d = lkp_mask & tx_full & ~src_oh;
            PATH_FLOOD:    mask_d = tx_full & ~src_oh;
            default:       mask_d = '0;
        endcase
    end

    always_comb begin
        if (!src_ok || rpt_active) learn_d = 1'b0;
        else if (from_cpu)         learn_d = 1'b1;
        else                       learn_d = !sel_ld;
    end

    // Decision state machine: state register.
    always_comb begin
        unique case (state_q)
            DEC_IDLE: state_d = req_valid ? DEC_OUT : DEC_IDLE;
            DEC_OUT:  state_d = req_valid ? DEC_OUT : DEC_IDLE;
            default:  state_d = DEC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DEC_IDLE;
        else        state_q <= state_d;
    end

    // Decision state machine: outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            learn_q <= 1'b0;
        end else if (req_valid) begin
            mask_q  <= mask_d;
            learn_q <= learn_d;
        end
    end

    assign res_valid   = (state_q == DEC_OUT);
    assign egress_mask = mask_q;
    assign learn_en    = learn_q;

    logic [NET-1:0] rx_shift;
    logic [NET-1:0] ld_shift;
    assign rx_shift = rx_en >> req_src;
    assign ld_shift = learn_dis >> req_src;

    // R2: a request produces a result exactly one cycle later
    a_r2_req_to_res: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2: no result without a request in the cycle before
    a_r2_res_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(req_valid));

    // R3: the ingress port is never in the egress mask
    a_r3_no_self: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (((egress_mask >> $past(req_src)) & NPORTS'(1)) == '0));

    // R5: closed receive side sends nothing to network ports
    a_r5_rx_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(rpt_active) && ($past(req_src) < PW'(CPU)) && !$past(rx_shift[0]))
        |-> ((egress_mask & net_bits) == '0));

    // R6: learn-disable on the ingress network port blocks learning
    a_r6_no_learn: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ($past(req_src) < PW'(CPU)) && $past(ld_shift[0])) |-> !learn_en);

    // R10: repeater mode never learns
    a_r10_rpt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(rpt_active)) |-> !learn_en);

endmodule

// File: rtl/fwd_mask_filter.sv
module fwd_mask_filter
    import fwd_pkg::*;
#(
    parameter int NPORTS = 3,
    localparam int NET   = NPORTS - 1,
    localparam int PW    = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PW-1:0]     cfg_port,
    input  logic [CODE_W-1:0] cfg_state,
    input  logic              rpt_en,
    input  logic [NPORTS-1:0] port_hd100,
    input  logic [NET-1:0]    an_off,
    input  logic              req_valid,
    input  logic [PW-1:0]     req_src,
    input  logic              lkp_hit,
    input  logic [NPORTS-1:0] lkp_mask,
    input  logic              lkp_override,
    input  logic              cpu_directed,
    output logic              res_valid,
    output logic [NPORTS-1:0] egress_mask,
    output logic              learn_en
);

    logic [NET-1:0] tx_en;
    logic [NET-1:0] rx_en;
    logic [NET-1:0] learn_dis;
    logic           rpt_active;

    for (genvar g = 0; g < NET; g++) begin : g_port
        stp_port_ctl u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (cfg_we && (cfg_port == PW'(g))),
            .wr_code   (cfg_state),
            .tx_en     (tx_en[g]),
            .rx_en     (rx_en[g]),
            .learn_dis (learn_dis[g])
        );
    end

    rpt_mode_fsm #(.NPORTS(NPORTS)) u_rpt (
        .clk        (clk),
        .rst_n      (rst_n),
        .rpt_en     (rpt_en),
        .port_hd100 (port_hd100),
        .an_off     (an_off),
        .rpt_active (rpt_active)
    );

    fwd_decide #(.NPORTS(NPORTS)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_src      (req_src),
        .lkp_hit      (lkp_hit),
        .lkp_mask     (lkp_mask),
        .lkp_override (lkp_override),
        .cpu_directed (cpu_directed),
        .tx_en        (tx_en),
        .rx_en        (rx_en),
        .learn_dis    (learn_dis),
        .rpt_active   (rpt_active),
        .res_valid    (res_valid),
        .egress_mask  (egress_mask),
        .learn_en     (learn_en)
    );

endmodule

// File: tb/fwd_mask_filter_bench.sv
module fwd_mask_filter_bench;

    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_port = '0;
    logic [2:0] cfg_state = '0;
    logic       rpt_en = 1'b0;
    logic [2:0] port_hd100 = '0;
    logic [1:0] an_off = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_src = '0;
    logic       lkp_hit = 1'b0;
    logic [2:0] lkp_mask = '0;
    logic       lkp_override = 1'b0;
    logic       cpu_directed = 1'b0;
    logic       res_valid;
    logic [2:0] egress_mask;
    logic       learn_en;

    int checks = 0;
    int errors = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    // Bench-side view of the configured permissions.
    logic m_tx[2];
    logic m_rx[2];
    logic m_ld[2];
    logic m_rpt = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    fwd_mask_filter u_fwd_mask_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_state(cfg_state), .rpt_en(rpt_en), .port_hd100(port_hd100),
        .an_off(an_off), .req_valid(req_valid), .req_src(req_src),
        .lkp_hit(lkp_hit), .lkp_mask(lkp_mask), .lkp_override(lkp_override),
        .cpu_directed(cpu_directed), .res_valid(res_valid),
        .egress_mask(egress_mask), .learn_en(learn_en)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got learn/mask %b expected %b", tag, act, exp);
        end
    endtask

    // Expected result built from the requirements.
    function automatic logic [3:0] model(input logic [1:0] src, input logic hit,
                                         input logic [2:0] lm, input logic ovr,
                                         input logic dir);
        logic [2:0] txm;
        logic [2:0] self;
        txm  = {1'b1, m_tx[1], m_tx[0]};
        if (src == 2'd3) return 4'b0000;                     // R12
        self = 3'b001 << src;
        if (m_rpt) return {1'b0, ~self};                     // R10
        if (src == 2'd2) begin
            if (dir) return {1'b1, lm & 3'b011};              // R9
            if (hit) return {1'b1, lm & txm & ~self};         // R8
            return {1'b1, txm & ~self};                       // R7
        end
        if (!m_rx[src[0]])                                    // R5
            return {!m_ld[src[0]], (hit && ovr) ? 3'b100 : 3'b000};
        if (hit) return {!m_ld[src[0]], lm & txm & ~self};
        return {!m_ld[src[0]], txm & ~self};
    endfunction

    task automatic set_port(input int p, input logic [2:0] code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = 2'(p); cfg_state = code;
        @(negedge clk);
        cfg_we = 1'b0;
        case (code)
            3'd0, 3'd1, 3'd2: begin m_tx[p] = 0; m_rx[p] = 0; m_ld[p] = 1; end
            3'd3:             begin m_tx[p] = 0; m_rx[p] = 0; m_ld[p] = 0; end
            3'd4:             begin m_tx[p] = 1; m_rx[p] = 1; m_ld[p] = 0; end
            default: ;        // R4: invalid code keeps state
        endcase
    endtask

    task automatic set_rpt(input logic en, input logic [2:0] hd, input logic [1:0] an);
        @(negedge clk);
        rpt_en = en; port_hd100 = hd; an_off = an;
        m_rpt = en && (&hd) && (&an);                         // R11
        @(negedge clk);
    endtask

    // Drive one request in the current negedge slot; leaves req_valid high.
    task automatic issue(input string tag, input logic [1:0] src, input logic hit,
                         input logic [2:0] lm, input logic ovr, input logic dir);
        req_valid = 1'b1; req_src = src; lkp_hit = hit; lkp_mask = lm;
        lkp_override = ovr; cpu_directed = dir;
        exp_q.push_back(model(src, hit, lm, ovr, dir));
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic req(input string tag, input logic [1:0] src, input logic hit,
                       input logic [2:0] lm, input logic ovr, input logic dir);
        @(negedge clk);
        issue(tag, src, hit, lm, ovr, dir);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: result without request, got %b expected none", {learn_en, egress_mask});
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {learn_en, egress_mask}, e);
            end
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_tx[i] = 0; m_rx[i] = 0; m_ld[i] = 1; end
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {learn_en, egress_mask}, 4'b0000);
        check("R1 reset valid", {3'b000, res_valid}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle no valid", {3'b000, res_valid}, 4'b0000);

        // Reset state: both ports disabled.
        req("R1 disabled drop", 2'd0, 1'b0, 3'b000, 1'b0, 1'b0);
        req("R1 cpu miss no tx", 2'd2, 1'b0, 3'b000, 1'b0, 1'b0);
        req("R5 override to cpu", 2'd0, 1'b1, 3'b010, 1'b1, 1'b0);
        req("R5 hit no override", 2'd1, 1'b1, 3'b100, 1'b0, 1'b0);

        set_port(0, 3'd4);
        set_port(1, 3'd4);
        req("R7 flood from 0", 2'd0, 1'b0, 3'b000, 1'b0, 1'b0);
        req("R3 R8 hit all from 1", 2'd1, 1'b1, 3'b111, 1'b0, 1'b0);
        req("R7 flood from cpu", 2'd2, 1'b0, 3'b000, 1'b0, 1'b0);
        req("R6 cpu learns", 2'd2, 1'b1, 3'b001, 1'b0, 1'b0);

        set_port(1, 3'd1);
        req("R7 flood skips blocked", 2'd0, 1'b0, 3'b000, 1'b0, 1'b0);
        req("R8 hit blocked port", 2'd0, 1'b1, 3'b010, 1'b0, 1'b0);
        req("R9 directed past tx", 2'd2, 1'b1, 3'b111, 1'b0, 1'b1);
        req("R8 cpu hit undirected", 2'd2, 1'b1, 3'b011, 1'b0, 1'b0);

        set_port(1, 3'd3);
        req("R6 learning state learns", 2'd1, 1'b0, 3'b000, 1'b0, 1'b0);
        set_port(1, 3'd7);
        req("R4 bad code keeps learning", 2'd1, 1'b0, 3'b000, 1'b0, 1'b0);
        set_port(1, 3'd5);
        req("R4 bad code 5 keeps", 2'd1, 1'b1, 3'b101, 1'b1, 1'b0);
        set_port(1, 3'd2);
        req("R4 R6 listening no learn", 2'd1, 1'b0, 3'b000, 1'b0, 1'b0);
        set_port(1, 3'd0);
        req("R4 disabled no learn", 2'd1, 1'b1, 3'b100, 1'b1, 1'b0);

        req("R12 unused source", 2'd3, 1'b1, 3'b111, 1'b0, 1'b0);

        // Repeater: qualification incomplete, then complete.
        set_port(1, 3'd4);
        set_rpt(1'b1, 3'b011, 2'b11);
        req("R11 unqualified ignored", 2'd0, 1'b1, 3'b001, 1'b0, 1'b0);
        set_rpt(1'b1, 3'b111, 2'b01);
        req("R11 autoneg on ignored", 2'd1, 1'b0, 3'b000, 1'b0, 1'b0);
        set_rpt(1'b1, 3'b111, 2'b11);
        req("R10 repeat from 0", 2'd0, 1'b1, 3'b001, 1'b0, 1'b0);
        req("R10 repeat from cpu", 2'd2, 1'b1, 3'b100, 1'b0, 1'b1);
        set_port(1, 3'd0);
        req("R10 repeat from 1", 2'd1, 1'b1, 3'b000, 1'b1, 1'b0);

        // Back-to-back requests in repeat mode.
        @(negedge clk);
        issue("R2 burst a", 2'd0, 1'b0, 3'b000, 1'b0, 1'b0);
        issue("R2 burst b", 2'd1, 1'b0, 3'b000, 1'b0, 1'b0);
        issue("R2 burst c", 2'd2, 1'b0, 3'b000, 1'b0, 1'b0);
        req_valid = 1'b0;
        @(negedge clk);

        set_rpt(1'b0, 3'b111, 2'b11);
        req("R11 repeat off again", 2'd0, 1'b0, 3'b000, 1'b0, 1'b0);
        req("R5 back to normal", 2'd1, 1'b1, 3'b100, 1'b1, 1'b0);

        repeat (3) @(negedge clk);
        check("R2 no lost results", {1'b0, 3'(exp_q.size())}, 4'b0000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule